// File: doc/BRIEF.md
# Four-Channel Output Compare Unit

This block drives four output pins from a free-running up counter and four compare registers. Software programs a small register set through a byte-wide write port with combinational read-back. The set holds one control byte with a global enable, a master-mode select and one initial pin level per channel, one byte of 2-bit per-channel action codes, and the compare values. Whenever the count equals a channel's compare value, that channel's pin is set, cleared, toggled or returned to its initial level.

In master mode only channel 0's action is evaluated, and its result drives all four pins. A control write with the enable bit set preloads every pin with its programmed level. The pins are registered. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `oc_unit`

## Requirements
- R1: While reset is asserted, all pins read 0, the count reads 0, and both control bytes read back as 0.
- R2: Register map. Address 0 is control: bit 0 enable, bit 1 master, bits 2..5 initial level of channels 0..3. Address 1 holds the action codes: channel 0 in [1:0], channel 1 in [3:2], channel 2 in [5:4], channel 3 in [7:6]. Compare byte b of channel i sits at address 2 + i*CMP_BYTES + b, least significant byte first, with CMP_BYTES = ceil(CNT_W/8). All of these read back what was written, and unused bits read 0.
- R3: The count rises by 1 every clock and wraps from all-ones to 0.
- R4: A match exists in the one cycle where the count equals a channel's compare value. The pin changes on the following clock edge, and without a match it holds.
- R5: Action code 01 clears the pin on a match, 10 sets it, and 11 toggles it.
- R6: Action code 00 drives the pin to that channel's initial-level bit on a match.
- R7: A control write with bit 0 set loads each pin with its initial level on that edge. In master mode every pin takes channel 0's level. The load wins over a match in the same cycle.
- R8: With enable at 0, matches change no pin, and a control write with bit 0 clear loads nothing.
- R9: Channels that match in the same cycle each apply their own action.
- R10: In master mode only channel 0's action is evaluated, its result goes to all pins, and matches on the other channels have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| count_o | output | CNT_W | Current counter value |
| oc_pins | output | NUM_CH | Registered compare output pins |

## Verification
The bench builds the unit with CNT_W = 8, NUM_CH = 4 and ADDR_W = 4. The counter therefore wraps every 256 cycles, and each channel needs a single compare byte, at addresses 2 to 5. The short period lets one run check that toggles repeat after a wrap, that a disabled unit ignores a later match, and that mode changes take effect on the next period's match. A control write is also timed to land in a match cycle to check that the load wins.

// File: rtl/oc_pkg.sv
`timescale 1ns/1ps
package oc_pkg;
  typedef enum logic [1:0] {
    OCM_INIT = 2'b00,
    OCM_CLR  = 2'b01,
    OCM_SET  = 2'b10,
    OCM_TOG  = 2'b11
  } oc_mode_e;

  localparam int CTL_ADDR  = 0;
  localparam int MODE_ADDR = 1;
  localparam int CMP_ADDR0 = 2;

  localparam int EN_BIT   = 0;
  localparam int MST_BIT  = 1;
  localparam int INIT_LSB = 2;
endpackage

// File: rtl/oc_regs.sv
`timescale 1ns/1ps
module oc_regs
  import oc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  output logic [7:0]              rdata,
  output logic                    oc_en,
  output logic                    master,
  output logic [NUM_CH-1:0]       init_lvl,
  output logic [2*NUM_CH-1:0]     mode_flat,
  output logic [NUM_CH*CNT_W-1:0] cmp_flat,
  output logic                    load,
  output logic [NUM_CH-1:0]       load_lvl
);
  localparam int CMP_BYTES = (CNT_W + 7) / 8;
  localparam int NUM_CMP   = NUM_CH * CMP_BYTES;
  localparam int CTL_W     = INIT_LSB + NUM_CH;
  localparam int MODE_W    = 2 * NUM_CH;

  logic [CTL_W-1:0]  ctl_q, ctl_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic [7:0]        cmp_q [NUM_CMP];
  logic [7:0]        cmp_d [NUM_CMP];
  logic              ctl_hit;

  assign ctl_hit = (addr == ADDR_W'(CTL_ADDR));

  always_comb begin
    ctl_d  = ctl_q;
    mode_d = mode_q;
    cmp_d  = cmp_q;
    if (ctl_hit) begin
      ctl_d = wdata[CTL_W-1:0];
    end else if (addr == ADDR_W'(MODE_ADDR)) begin
      mode_d = wdata[MODE_W-1:0];
    end else begin
      for (int k = 0; k < NUM_CMP; k++) begin
        if (addr == ADDR_W'(CMP_ADDR0 + k)) cmp_d[k] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      mode_q <= '0;
      for (int k = 0; k < NUM_CMP; k++) cmp_q[k] <= '0;
    end else if (wr_en) begin
      ctl_q  <= ctl_d;
      mode_q <= mode_d;
      for (int k = 0; k < NUM_CMP; k++) cmp_q[k] <= cmp_d[k];
    end
  end

  always_comb begin
    rdata = '0;
    if (ctl_hit) begin
      rdata = 8'(ctl_q);
    end else if (addr == ADDR_W'(MODE_ADDR)) begin
      rdata = 8'(mode_q);
    end else begin
      for (int k = 0; k < NUM_CMP; k++) begin
        if (addr == ADDR_W'(CMP_ADDR0 + k)) rdata = cmp_q[k];
      end
    end
  end

  assign oc_en     = ctl_q[EN_BIT];
  assign master    = ctl_q[MST_BIT];
  assign init_lvl  = ctl_q[INIT_LSB +: NUM_CH];
  assign mode_flat = mode_q;
  assign load      = wr_en && ctl_hit && wdata[EN_BIT];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [CMP_BYTES*8-1:0] full;
    for (genvar b = 0; b < CMP_BYTES; b++) begin : g_byte
      assign full[b*8 +: 8] = cmp_q[ch*CMP_BYTES + b];
    end
    assign cmp_flat[ch*CNT_W +: CNT_W] = full[CNT_W-1:0];
    assign load_lvl[ch] = wdata[MST_BIT] ? wdata[INIT_LSB] : wdata[INIT_LSB + ch];
  end

  // R2: a control write is visible on the decoded enable on the next cycle
  a_r2_ctl_written: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ctl_hit) |=> (oc_en == $past(wdata[EN_BIT])));
endmodule

// File: rtl/oc_counter.sv
`timescale 1ns/1ps
module oc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  assign cnt_ce = 1'b1;
  assign cnt_d  = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R3: steady increment with natural wrap
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));
endmodule

// File: rtl/oc_chan.sv
`timescale 1ns/1ps
module oc_chan
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             cur,
  input  logic             init,
  input  oc_mode_e         mode,
  output logic             hit,
  output logic             nxt
);
  assign hit = (cnt == cmp);

  always_comb begin
    nxt = cur;
    if (hit) begin
      case (mode)
        OCM_INIT: nxt = init;
        OCM_CLR:  nxt = 1'b0;
        OCM_SET:  nxt = 1'b1;
        OCM_TOG:  nxt = ~cur;
        default:  nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/oc_unit.sv
`timescale 1ns/1ps
module oc_unit
  import oc_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [CNT_W-1:0]  count_o,
  output logic [NUM_CH-1:0] oc_pins
);
  logic [1:0]              rst_ff;
  logic                    rst_sync_n;
  logic                    oc_en, master, load;
  logic [NUM_CH-1:0]       init_lvl, load_lvl;
  logic [2*NUM_CH-1:0]     mode_flat;
  logic [NUM_CH*CNT_W-1:0] cmp_flat;
  logic [CNT_W-1:0]        cnt;
  logic [NUM_CH-1:0]       hit, nxt;
  logic [NUM_CH-1:0]       pin_q, pin_d;
  logic                    pin_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  oc_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .oc_en(oc_en), .master(master),
    .init_lvl(init_lvl), .mode_flat(mode_flat), .cmp_flat(cmp_flat),
    .load(load), .load_lvl(load_lvl)
  );

  oc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .cnt(cnt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    oc_chan #(.CNT_W(CNT_W)) u_chan (
      .cnt(cnt), .cmp(cmp_flat[i*CNT_W +: CNT_W]), .cur(pin_q[i]),
      .init(init_lvl[i]), .mode(oc_mode_e'(mode_flat[2*i +: 2])),
      .hit(hit[i]), .nxt(nxt[i])
    );
  end

  always_comb begin
    pin_d  = pin_q;
    pin_ce = load | oc_en;
    if (load) begin
      pin_d = load_lvl;
    end else if (oc_en) begin
      for (int i = 0; i < NUM_CH; i++) pin_d[i] = master ? nxt[0] : nxt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  pin_q <= '0;
    else if (pin_ce)  pin_q <= pin_d;
  end

  assign oc_pins = pin_q;
  assign count_o = cnt;

  // R7: enable write preloads pins from the written control byte
  a_r7_preload: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> (pin_q == $past(load_lvl)));
  // R8: disabled unit without a load keeps its pins
  a_r8_disabled_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!oc_en && !load) |=> $stable(pin_q));
  // R4: no match anywhere means no pin movement
  a_r4_no_hit_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load && hit == '0) |=> $stable(pin_q));
  // R10: master mode leaves all pins equal
  a_r10_master_equal: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_en && master && !load) |=> (pin_q == '0 || pin_q == '1));
  // R5: channel 0 clear, set and toggle actions
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_en && !load && hit[0] && mode_flat[1:0] == 2'b01) |=> !pin_q[0]);
  a_r5_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_en && !load && hit[0] && mode_flat[1:0] == 2'b10) |=> pin_q[0]);
  a_r5_toggle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (oc_en && !load && hit[0] && mode_flat[1:0] == 2'b11) |=> (pin_q[0] != $past(pin_q[0])));
endmodule

// File: tb/oc_unit_test.sv
`timescale 1ns/1ps
module oc_unit_test;
  localparam int NUM_CH = 4;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [ADDR_W-1:0] reg_addr;
  logic [7:0]        reg_wdata;
  logic [7:0]        reg_rdata;
  logic [CNT_W-1:0]  count_o;
  logic [NUM_CH-1:0] oc_pins;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [11:0] sb_q[$];
  string       sb_tag[$];

  always #2.5 clk = ~clk;

  oc_unit #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o),
    .oc_pins(oc_pins)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] key, logic [3:0] pins, string tag);
    sb_q.push_back({key, pins});
    sb_tag.push_back(tag);
  endtask

  // monitor: compares pins when the count reaches the expected item's key
  always @(negedge clk) begin
    if (sb_q.size() != 0 && count_o == sb_q[0][11:4]) begin
      check(sb_tag[0], 32'(oc_pins), 32'(sb_q[0][3:0]));
      void'(sb_q.pop_front());
      void'(sb_tag.pop_front());
    end
  end

  task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wr_when(logic [7:0] target, logic [ADDR_W-1:0] a, logic [7:0] d);
    do @(negedge clk); while (count_o != target);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, b, c, d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pins", 32'(oc_pins), 0);
    check("R1 count", 32'(count_o), 0);
    rd(0, v); check("R1 ctl", 32'(v), 0);
    rd(1, v); check("R1 mode", 32'(v), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 increment and wrap
    do @(negedge clk); while (count_o != 8'hFF);
    @(negedge clk); check("R3 wrap", 32'(count_o), 0);
    @(negedge clk); check("R3 step", 32'(count_o), 1);

    // Scenario A: independent channels, set/clear/toggle/init
    b = count_o + 8'd40;
    wr(0, 8'h00);
    wr(1, 8'h36);               // ch3 00, ch2 11, ch1 01, ch0 10
    wr(2, b);
    wr(3, 8'(b + 8'd5));
    wr(4, 8'(b + 8'd10));
    wr(5, 8'(b + 8'd15));
    wr(0, 8'h29);               // enable, init ch1 and ch3
    check("R7 load", 32'(oc_pins), 32'hA);
    rd(1, v); check("R2 mode readback", 32'(v), 32'h36);
    rd(0, v); check("R2 ctl readback", 32'(v), 32'h29);
    rd(5, v); check("R2 cmp3 readback", 32'(v), 32'(8'(b + 8'd15)));
    push(8'(b + 8'd1),  4'b1011, "R5 set");
    push(8'(b + 8'd6),  4'b1001, "R5 clear");
    push(8'(b + 8'd11), 4'b1101, "R5 toggle");
    push(8'(b + 8'd16), 4'b1101, "R6 init hold");
    push(8'(b + 8'd1),  4'b1101, "R4 set repeat");
    push(8'(b + 8'd11), 4'b1001, "R3 toggle after wrap");
    drain();

    // R8 disabled: no load, no match effect
    wr(0, 8'h00);
    check("R8 no load", 32'(oc_pins), 32'h9);
    push(8'(b + 8'd11), 4'b1001, "R8 match ignored");
    drain();

    // Scenario master
    c = count_o + 8'd30;
    wr(1, 8'h0B);               // ch1 10, ch0 11
    wr(2, c);
    wr(3, 8'(c + 8'd5));
    wr(4, 8'(c + 8'd5));
    wr(5, 8'(c + 8'd5));
    wr(0, 8'h07);               // enable, master, init ch0
    check("R10 master load", 32'(oc_pins), 32'hF);
    push(8'(c + 8'd1), 4'b0000, "R10 ch0 copied");
    push(8'(c + 8'd6), 4'b0000, "R10 others ignored");
    drain();

    // Scenario simultaneous matches and init code
    d = count_o + 8'd30;
    wr(0, 8'h00);
    wr(1, 8'hEB);               // ch3 11, ch2 10, ch1 10, ch0 11
    wr(2, d);
    wr(3, d);
    wr(4, d);
    wr(5, 8'(d + 8'd3));
    wr(0, 8'h01);
    check("R7 load zeros", 32'(oc_pins), 0);
    push(8'(d + 8'd1), 4'b0111, "R9 simultaneous");
    push(8'(d + 8'd4), 4'b1111, "R5 toggle ch3");
    drain();
    wr(1, 8'hE8);               // ch0 becomes 00
    push(8'(d + 8'd1), 4'b1110, "R6 init on match");
    push(8'(d + 8'd4), 4'b0110, "R5 toggle ch3 back");
    drain();

    // R7 load wins over a match in the same cycle
    wr_when(d, 0, 8'h3D);       // enable, all init levels 1
    check("R7 load beats match", 32'(oc_pins), 32'hF);
    push(8'(d + 8'd4), 4'b0111, "R5 toggle after load");
    drain();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule